// File: doc/BRIEF.md
# SPI Event Flag, Interrupt and Halt-Wake Controller

This block holds the status flags of a serial peripheral and turns them into one interrupt request. It also manages the peripheral's low-power behaviour. The shift engine is outside the block and appears only as two one-cycle strobes: one for a finished byte and one for a mode fault. Software acknowledges flags with a status-read strobe followed by a data-read strobe.

While the device idles in its light sleep state, the peripheral keeps running and any enabled event ends that sleep. In deep sleep (halt) every flag is frozen. A slave can still wake the device with a completed transfer, but only if it was selected when halt began. The selection comes from the external pin or from an internal bit, chosen by a source input. The wake is a one-cycle pulse. After a wake in slave mode, the next completed transfer only restores normal operation and leaves the flags unchanged.

Top module: `spi_irq_wake_ctrl`

## Requirements
- R1: After reset all three flags, the interrupt, the wake pulse, the light-sleep exit and the recovery indication are 0.
- R2: A transfer-done strobe sets the transfer flag one cycle later. If the flag was already set and is not being cleared in that cycle, the overrun flag is also set.
- R3: A data-read strobe clears all flags only after an earlier status-read strobe that saw at least one flag set. A data-read strobe without such a status read changes nothing.
- R4: A mode-fault strobe sets the mode-fault flag one cycle later.
- R5: `irq_o` is high exactly when the global mask is low and either (transfer flag AND transfer enable) or ((mode-fault OR overrun flag) AND error enable) holds.
- R6: In light sleep the flags keep updating, and `wait_exit_o` follows `irq_o`.
- R7: While halt is requested, `freeze_o` is high and no strobe, status read or data read changes any flag, except the single wake capture of R8.
- R8: During halt, in slave mode, with slave select sampled low at halt entry, the first transfer-done strobe produces a one-cycle `wake_o` pulse in the following cycle. It also updates the flags as in R2. Later strobes in the same halt are ignored.
- R9: If the slave select chosen by `ss_src_i` (0 = pin, 1 = internal bit; active low) was high at halt entry, no wake occurs in that halt, even if select later goes low.
- R10: A mode fault, or a transfer in master mode, never wakes the device.
- R11: A wake raises `recovering_o`. While it is high, `RECOVER_XFERS` transfer-done strobes outside halt are consumed without touching the flags. Leaving slave mode drops it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_done_i | input | 1 | Transfer finished strobe |
| mfault_i | input | 1 | Mode fault strobe |
| slave_mode_i | input | 1 | 1 = peripheral is slave |
| ss_src_i | input | 1 | Slave-select source: 0 pin, 1 internal bit |
| ss_pin_n_i | input | 1 | Slave-select pin level, active low |
| ss_bit_n_i | input | 1 | Internal slave-select bit, active low |
| stat_rd_i | input | 1 | Status read strobe |
| data_rd_i | input | 1 | Data read strobe |
| xfer_ie_i | input | 1 | Transfer interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| gmask_i | input | 1 | Global interrupt mask |
| wait_req_i | input | 1 | Light sleep active |
| halt_req_i | input | 1 | Deep sleep (halt) active |
| xfer_flag_o | output | 1 | Transfer flag |
| mfault_flag_o | output | 1 | Mode fault flag |
| ovr_flag_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Combined interrupt request |
| wait_exit_o | output | 1 | Light sleep exit request |
| wake_o | output | 1 | Halt wake pulse |
| freeze_o | output | 1 | Flags frozen |
| recovering_o | output | 1 | Post-wake recovery in progress |

## Verification
The bench sweeps every combination of mask and enables against each flag pattern. A wrong interrupt term would show up as a request under the mask, or as a missing request. It samples slave select at halt entry and then changes it. A design that looks at the live level would wake after a deselected entry. It sends further strobes, reads and faults during halt, where a leaky freeze would change flags or pulse the wake twice. It also checks that the transfer after a wake is swallowed and that a design without recovery would raise overrun there.

// File: rtl/spi_wake_pkg.sv
package spi_wake_pkg;
   typedef struct packed {
      logic xfer;
      logic mfault;
      logic ovr;
   } spi_flags_t;

   localparam int NUM_FLAGS = $bits(spi_flags_t);

   function automatic logic any_flag(input spi_flags_t f);
      return |f;
   endfunction
endpackage

// File: rtl/spi_flag_bank.sv
module spi_flag_bank
   import spi_wake_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_i,
   input  logic       xfer_evt_i,
   input  logic       mfault_evt_i,
   input  logic       stat_rd_i,
   input  logic       data_rd_i,
   output spi_flags_t flags_o
);
   spi_flags_t flags_q, flags_d;
   logic       arm_q;
   logic       clr;

   assign clr = ~hold_i & data_rd_i & arm_q;

   always_comb begin
      flags_d = clr ? '0 : flags_q;
      if (xfer_evt_i) begin
         if (flags_q.xfer && !clr) flags_d.ovr = 1'b1;
         flags_d.xfer = 1'b1;
      end
      if (mfault_evt_i && !hold_i) flags_d.mfault = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         arm_q   <= 1'b0;
      end else begin
         flags_q <= flags_d;
         if (!hold_i) begin
            if (data_rd_i)                           arm_q <= 1'b0;
            else if (stat_rd_i && any_flag(flags_q)) arm_q <= 1'b1;
         end
      end
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/spi_halt_wake.sv
module spi_halt_wake #(
   parameter int RECOVER_XFERS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_req_i,
   input  logic slave_mode_i,
   input  logic ss_src_i,
   input  logic ss_pin_n_i,
   input  logic ss_bit_n_i,
   input  logic xfer_done_i,
   output logic wake_hit_o,
   output logic wake_o,
   output logic recovering_o
);
   localparam int CNT_W = (RECOVER_XFERS < 2) ? 1 : $clog2(RECOVER_XFERS + 1);

   if (RECOVER_XFERS < 1) begin : g_bad_param
      $error("RECOVER_XFERS must be at least 1");
   end

   logic halt_q, armed_q, used_q, wake_q;
   logic ss_n_eff, entry, armed_d, hit;

   assign ss_n_eff = ss_src_i ? ss_bit_n_i : ss_pin_n_i;
   assign entry    = halt_req_i & ~halt_q;
   assign armed_d  = entry ? ~ss_n_eff : armed_q;
   assign hit      = halt_req_i & armed_d & slave_mode_i & xfer_done_i & ~used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q  <= 1'b0;
         armed_q <= 1'b0;
         used_q  <= 1'b0;
         wake_q  <= 1'b0;
      end else begin
         halt_q  <= halt_req_i;
         armed_q <= halt_req_i & armed_d;
         used_q  <= halt_req_i & (used_q | hit);
         wake_q  <= hit;
      end
   end

   if (RECOVER_XFERS == 1) begin : g_rec_bit
      logic rec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    rec_q <= 1'b0;
         else if (hit)                  rec_q <= 1'b1;
         else if (rec_q && (!slave_mode_i || (xfer_done_i && !halt_req_i)))
                                        rec_q <= 1'b0;
      end
      assign recovering_o = rec_q;
   end else begin : g_rec_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt_q <= '0;
         else if (hit)                        cnt_q <= CNT_W'(RECOVER_XFERS);
         else if (cnt_q != '0) begin
            if (!slave_mode_i)                cnt_q <= '0;
            else if (xfer_done_i && !halt_req_i) cnt_q <= cnt_q - 1'b1;
         end
      end
      assign recovering_o = (cnt_q != '0);
   end

   assign wake_hit_o = hit;
   assign wake_o     = wake_q;
endmodule

// File: rtl/spi_irq_merge.sv
module spi_irq_merge
   import spi_wake_pkg::*;
(
   input  spi_flags_t flags_i,
   input  logic       xfer_ie_i,
   input  logic       err_ie_i,
   input  logic       gmask_i,
   input  logic       wait_req_i,
   output logic       irq_o,
   output logic       wait_exit_o
);
   logic xfer_src, err_src;
   assign xfer_src    = flags_i.xfer & xfer_ie_i;
   assign err_src     = (flags_i.mfault | flags_i.ovr) & err_ie_i;
   assign irq_o       = ~gmask_i & (xfer_src | err_src);
   assign wait_exit_o = wait_req_i & irq_o;
endmodule

// File: rtl/spi_irq_wake_ctrl.sv
module spi_irq_wake_ctrl
   import spi_wake_pkg::*;
#(
   parameter int RECOVER_XFERS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_done_i,
   input  logic mfault_i,
   input  logic slave_mode_i,
   input  logic ss_src_i,
   input  logic ss_pin_n_i,
   input  logic ss_bit_n_i,
   input  logic stat_rd_i,
   input  logic data_rd_i,
   input  logic xfer_ie_i,
   input  logic err_ie_i,
   input  logic gmask_i,
   input  logic wait_req_i,
   input  logic halt_req_i,
   output logic xfer_flag_o,
   output logic mfault_flag_o,
   output logic ovr_flag_o,
   output logic irq_o,
   output logic wait_exit_o,
   output logic wake_o,
   output logic freeze_o,
   output logic recovering_o
);
   spi_flags_t flags;
   logic       wake_hit, recovering, xfer_evt;

   spi_halt_wake #(.RECOVER_XFERS(RECOVER_XFERS)) u_wake (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_req_i   (halt_req_i),
      .slave_mode_i (slave_mode_i),
      .ss_src_i     (ss_src_i),
      .ss_pin_n_i   (ss_pin_n_i),
      .ss_bit_n_i   (ss_bit_n_i),
      .xfer_done_i  (xfer_done_i),
      .wake_hit_o   (wake_hit),
      .wake_o       (wake_o),
      .recovering_o (recovering)
   );

   assign xfer_evt = wake_hit | (xfer_done_i & ~halt_req_i & ~recovering);

   spi_flag_bank u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .hold_i       (halt_req_i),
      .xfer_evt_i   (xfer_evt),
      .mfault_evt_i (mfault_i),
      .stat_rd_i    (stat_rd_i),
      .data_rd_i    (data_rd_i),
      .flags_o      (flags)
   );

   spi_irq_merge u_irq (
      .flags_i     (flags),
      .xfer_ie_i   (xfer_ie_i),
      .err_ie_i    (err_ie_i),
      .gmask_i     (gmask_i),
      .wait_req_i  (wait_req_i),
      .irq_o       (irq_o),
      .wait_exit_o (wait_exit_o)
   );

   assign xfer_flag_o   = flags.xfer;
   assign mfault_flag_o = flags.mfault;
   assign ovr_flag_o    = flags.ovr;
   assign freeze_o      = halt_req_i;
   assign recovering_o  = recovering;
endmodule

// File: rtl/spi_irq_wake_chk.sv
module spi_irq_wake_chk (
   input logic clk,
   input logic rst_n,
   input logic xfer_done_i,
   input logic slave_mode_i,
   input logic gmask_i,
   input logic halt_req_i,
   input logic xfer_flag_o,
   input logic mfault_flag_o,
   input logic ovr_flag_o,
   input logic irq_o,
   input logic wake_o,
   input logic recovering_o
);
   p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> ($past(halt_req_i) && $past(slave_mode_i) && $past(xfer_done_i)));

   p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o);

   p_wake_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> xfer_flag_o);

   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(halt_req_i) && !wake_o) |-> $stable({xfer_flag_o, mfault_flag_o, ovr_flag_o}));

   p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gmask_i |-> !irq_o);

   p_ovr_with_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag_o) |-> xfer_flag_o);

   p_recover_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(recovering_o) |-> ($past(xfer_done_i) || !$past(slave_mode_i)));
endmodule

bind spi_irq_wake_ctrl spi_irq_wake_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .xfer_done_i   (xfer_done_i),
   .slave_mode_i  (slave_mode_i),
   .gmask_i       (gmask_i),
   .halt_req_i    (halt_req_i),
   .xfer_flag_o   (xfer_flag_o),
   .mfault_flag_o (mfault_flag_o),
   .ovr_flag_o    (ovr_flag_o),
   .irq_o         (irq_o),
   .wake_o        (wake_o),
   .recovering_o  (recovering_o)
);

// File: tb/test_spi_irq_wake_ctrl.sv
`timescale 1ns/1ps
module test_spi_irq_wake_ctrl;
   logic clk = 1'b0;
   logic rst_n;
   logic xfer_done, mfault, slave_mode, ss_src, ss_pin_n, ss_bit_n;
   logic stat_rd, data_rd, xfer_ie, err_ie, gmask, wait_req, halt_req;
   logic xfer_flag, mfault_flag, ovr_flag, irq, wait_exit, wake, freeze, recovering;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   spi_irq_wake_ctrl i_spi_irq_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .xfer_done_i(xfer_done), .mfault_i(mfault),
      .slave_mode_i(slave_mode), .ss_src_i(ss_src), .ss_pin_n_i(ss_pin_n),
      .ss_bit_n_i(ss_bit_n), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
      .xfer_ie_i(xfer_ie), .err_ie_i(err_ie), .gmask_i(gmask),
      .wait_req_i(wait_req), .halt_req_i(halt_req),
      .xfer_flag_o(xfer_flag), .mfault_flag_o(mfault_flag), .ovr_flag_o(ovr_flag),
      .irq_o(irq), .wait_exit_o(wait_exit), .wake_o(wake), .freeze_o(freeze),
      .recovering_o(recovering)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [7:0] flg();
      return {5'b0, xfer_flag, mfault_flag, ovr_flag};
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_xfer();  xfer_done = 1; tick(); xfer_done = 0; endtask
   task automatic pulse_fault(); mfault = 1;    tick(); mfault = 0;    endtask
   task automatic pulse_stat();  stat_rd = 1;   tick(); stat_rd = 0;   endtask
   task automatic pulse_data();  data_rd = 1;   tick(); data_rd = 0;   endtask

   task automatic sweep_irq(input string req);
      for (int v = 0; v < 8; v++) begin
         logic exp_irq;
         {gmask, xfer_ie, err_ie} = 3'(v);
         #1;
         exp_irq = !gmask && ((xfer_flag && xfer_ie) || ((mfault_flag || ovr_flag) && err_ie));
         chk(req, {7'b0, irq}, {7'b0, exp_irq});
      end
      {gmask, xfer_ie, err_ie} = 3'b011;
      tick();
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; xfer_done = 0; mfault = 0; slave_mode = 1; ss_src = 0;
      ss_pin_n = 1; ss_bit_n = 1; stat_rd = 0; data_rd = 0;
      xfer_ie = 1; err_ie = 1; gmask = 0; wait_req = 0; halt_req = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1", {flg()[2:0], irq, wait_exit, wake, freeze, recovering}, 8'b0);

      // R2 set and overrun
      pulse_xfer();
      chk("R2 set", flg(), 8'b100);
      sweep_irq("R5 xfer flag");
      pulse_xfer();
      chk("R2 overrun", flg(), 8'b101);
      sweep_irq("R5 xfer+ovr");

      // R3 clear sequence
      pulse_data();
      chk("R3 data alone", flg(), 8'b101);
      pulse_stat();
      pulse_data();
      chk("R3 cleared", flg(), 8'b000);
      sweep_irq("R5 no flag");

      // R4 mode fault
      pulse_fault();
      chk("R4", flg(), 8'b010);
      sweep_irq("R5 fault");

      // R6 light sleep
      wait_req = 1;
      #1 chk("R6 exit", {7'b0, wait_exit}, 8'd1);
      pulse_xfer();
      chk("R6 flags run", flg(), 8'b110);
      pulse_stat(); pulse_data();
      chk("R3 clear all", flg(), 8'b000);
      #1 chk("R6 no exit", {7'b0, wait_exit}, 8'd0);
      wait_req = 0;

      // R7/R8 halt with select low
      ss_pin_n = 0; halt_req = 1; tick();
      chk("R7 freeze", {7'b0, freeze}, 8'd1);
      pulse_fault();
      chk("R10 fault no wake", {5'b0, wake, flg()[1:0]}, 8'b0);
      chk("R7 fault frozen", flg(), 8'b000);
      pulse_xfer();
      chk("R8 wake", {6'b0, wake, xfer_flag}, 8'b11);
      tick();
      chk("R8 one cycle", {7'b0, wake}, 8'd0);
      pulse_xfer();
      chk("R8 only first", {5'b0, wake, ovr_flag, xfer_flag}, 8'b001);
      pulse_stat(); pulse_data();
      chk("R7 reads frozen", flg(), 8'b100);
      halt_req = 0; tick();
      chk("R11 recovering", {7'b0, recovering}, 8'd1);
      pulse_xfer();
      chk("R11 consumed", {4'b0, recovering, flg()[2:0]}, 8'b0100);
      pulse_xfer();
      chk("R2 after recovery", flg(), 8'b101);
      pulse_stat(); pulse_data();

      // R9 select high at entry
      ss_pin_n = 1; halt_req = 1; tick();
      ss_pin_n = 0;
      pulse_xfer();
      tick();
      chk("R9 no wake", {5'b0, wake, flg()[1:0]}, 8'b0);
      chk("R9 flags", flg(), 8'b000);
      halt_req = 0; tick();

      // R9 internal source selects the bit
      ss_src = 1; ss_bit_n = 0; ss_pin_n = 1; halt_req = 1; tick();
      pulse_xfer();
      chk("R9 internal wake", {7'b0, wake}, 8'd1);
      halt_req = 0; tick();
      slave_mode = 0; tick();
      chk("R11 leave slave", {7'b0, recovering}, 8'd0);
      slave_mode = 1;
      pulse_stat(); pulse_data();
      chk("R3 clear", flg(), 8'b000);

      // R10 master mode never wakes
      slave_mode = 0; halt_req = 1; tick();
      pulse_xfer();
      chk("R10 master", {4'b0, wake, flg()[2:0]}, 8'b0);
      halt_req = 0; slave_mode = 1; tick();

      // R8 wake with flag pending gives overrun
      pulse_xfer();
      halt_req = 1; tick();
      pulse_xfer();
      chk("R8 wake overrun", {4'b0, wake, flg()[2:0]}, 8'b1101);
      halt_req = 0; tick();
      pulse_xfer();
      chk("R11 recovery keeps flags", {4'b0, recovering, flg()[2:0]}, 8'b0101);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule